// File: doc/BRIEF.md
# MDIO Management Controller

This block is a management-bus master for Ethernet PHYs. Software programs it through two 32-bit registers on a simple valid/ready register port. The control register sets the MDC clock divider and an enable bit. It also holds a fault flag and a fault-enable bit as plain storage, and it reports an idle status. The command register takes one word that both launches a clause-22 read or write frame and later returns the result.

When a command word with its start flag set is written, the block serialises a 64-bit frame on MDC/MDIO: 32 preamble ones, the start code, the opcode, the PHY address, the register number, the turnaround and 16 data bits, all MSB first. MDIO output changes only on falling MDC edges. On a read the block releases the line from the turnaround onward and samples on rising MDC edges. It latches whether the PHY pulled the second turnaround bit low, and it writes the 16 received bits back into the data field of the command register. The start flag reads back as 1 for as long as the frame is running. Software polls it to know when the result is ready.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read 0, MDC is low and MDIO is released (output enable low). Whenever no frame is running, MDC stays low and MDIO stays released.
- R2: Control register (address 0) fields read back as written: divider in bits 15:0, fault-enable in bit 18, fault flag in bit 19, enable in bit 30. Bit 31 (idle) reads 1 only while the block is enabled and no frame is running.
- R3: Command register (address 1) layout: GO in bit 31, write-select in bit 30 (1 = write, 0 = read), ACK in bit 29, register number in bits 25:21, PHY address in bits 20:16, data in bits 15:0. A write with GO=1 while the block is enabled and idle starts a frame. GO then reads 1 until the frame has fully ended.
- R4: The MDC period is L+1 clock cycles, where L is the divider latched at the start of the frame, with a divider of 0 treated as 1. Each period starts with (L+1)/2 low cycles, rounded down, and each frame lasts exactly 64 MDC periods.
- R5: The frame bits are sent MSB first, in this order: 32 ones, start 01, opcode 10 for a read or 01 for a write, 5-bit PHY address, 5-bit register number, turnaround, 16 data bits. MDIO output and its enable change only when MDC falls.
- R6: On a write the block drives MDIO for all 64 bits, with the turnaround sent as 10 followed by the 16 data bits.
- R7: On a read the block releases MDIO from the first turnaround bit to the end of the frame. It samples the 16 data bits on rising MDC edges. When GO clears, command bits 15:0 hold those bits.
- R8: ACK is cleared when a frame starts. After a read it is 1 only if MDIO was low at the rising MDC edge of the second turnaround bit. After a write it reads 0.
- R9: A command-register write while GO is 1 is ignored: the running frame continues unchanged and the stored fields are not altered.
- R10: With enable at 0, a command written with GO=1 starts no frame, GO reads 0 and the MDIO lines stay idle.
- R11: A read request is answered in the next cycle with rsp_valid high for exactly one cycle; req_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address (0 control, 1 command) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Sampled level of the MDIO pin |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest situation to reach is a command write that arrives while a frame is running. It is ignored only if it leaves no trace, either in the serial waveform or in the stored fields that the command register later returns. The bench starts a write frame and, about thirty cycles later, issues a second GO command with different fields. Its per-cycle waveform model keeps comparing MDC and MDIO against the first command until the end of the frame. The final readback must still show the first command's data. Turnaround acknowledge is also exercised in both directions: a PHY model that pulls the line low, one that leaves it high, and a write frame that follows an acknowledged read, which checks that ACK is cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int WORD_W  = 32;
    localparam int DIV_W   = 16;
    localparam int PHY_W   = 5;
    localparam int REGN_W  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_W   = 32;
    localparam int FRAME_W = PRE_W + 2 + 2 + PHY_W + REGN_W + 2 + DATA_W;
    localparam int TA_IDX  = PRE_W + 4 + PHY_W + REGN_W;
    localparam int RD_IDX  = TA_IDX + 2;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMD  = 1;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    typedef struct packed {
        logic              idle;
        logic              en;
        logic [9:0]        rsv_hi;
        logic              fault;
        logic              fault_en;
        logic [1:0]        rsv_lo;
        logic [DIV_W-1:0]  div;
    } ctrl_word_t;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic              ack;
        logic [2:0]        rsv;
        logic [REGN_W-1:0] regn;
        logic [PHY_W-1:0]  phy;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic              wr,
        input logic [PHY_W-1:0]  phy,
        input logic [REGN_W-1:0] regn,
        input logic [DATA_W-1:0] wdat
    );
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        op = wr ? 2'b01 : 2'b10;
        ta = wr ? 2'b10 : 2'b11;
        d  = wr ? wdat : {DATA_W{1'b1}};
        return {{PRE_W{1'b1}}, 2'b01, op, phy, regn, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             fall_tick,
    output logic             rise_tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic [DIV_W:0]   half_w;
    logic [DIV_W-1:0] half;
    logic             unused_half_msb;

    assign half_w          = ({1'b0, lim} + (DIV_W+1)'(1)) >> 1;
    assign half            = half_w[DIV_W-1:0];
    assign unused_half_msb = half_w[DIV_W];

    assign fall_tick = run && (cnt == '0);
    assign rise_tick = run && (cnt == half);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= DIV_W'(1);
        end else if (start) begin
            cnt <= '0;
            lim <= (div_in == '0) ? DIV_W'(1) : div_in;
        end else if (run) begin
            cnt <= (cnt == lim) ? '0 : cnt + DIV_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim)); // R4

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cmd_word_t         cmd,
    input  logic              fall_tick,
    input  logic              rise_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_oe
);

    localparam int POS_W = $clog2(FRAME_W + 1);
    localparam logic [POS_W-1:0] POS_END = POS_W'(FRAME_W);
    localparam logic [POS_W-1:0] POS_TA  = POS_W'(TA_IDX);
    localparam logic [POS_W-1:0] POS_ACK = POS_W'(RD_IDX);

    eng_state_t         state;
    logic               wr_q;
    logic [FRAME_W-1:0] shreg;
    logic [DATA_W-1:0]  rsh;
    logic [POS_W-1:0]   pos;
    logic               ack_q;
    logic               mdc_q;
    logic               mdo_q;
    logic               oe_q;
    logic               unused_cmd;

    assign unused_cmd = ^{cmd.go, cmd.ack, cmd.rsv};

    assign busy   = (state == ENG_RUN);
    assign done   = busy && fall_tick && (pos == POS_END);
    assign ack    = ack_q;
    assign rdata  = rsh;
    assign mdc    = mdc_q;
    assign mdo    = mdo_q;
    assign mdo_oe = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            wr_q  <= 1'b0;
            shreg <= '0;
            rsh   <= '0;
            pos   <= '0;
            ack_q <= 1'b0;
            mdc_q <= 1'b0;
            mdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state <= ENG_RUN;
                        wr_q  <= cmd.wr;
                        shreg <= build_frame(cmd.wr, cmd.phy, cmd.regn, cmd.data);
                        rsh   <= '0;
                        pos   <= '0;
                        ack_q <= 1'b0;
                    end
                end
                ENG_RUN: begin
                    if (fall_tick) begin
                        mdc_q <= 1'b0;
                        if (pos == POS_END) begin
                            state <= ENG_IDLE;
                            mdo_q <= 1'b0;
                            oe_q  <= 1'b0;
                        end else begin
                            mdo_q <= shreg[FRAME_W-1];
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                            oe_q  <= wr_q || (pos < POS_TA);
                            pos   <= pos + POS_W'(1);
                        end
                    end else if (rise_tick) begin
                        mdc_q <= 1'b1;
                        if (!wr_q) begin
                            if (pos == POS_ACK) begin
                                ack_q <= !mdio_i;
                            end else if (pos > POS_ACK) begin
                                rsh <= {rsh[DATA_W-2:0], mdio_i};
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc_q && !oe_q)); // R1
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R9
    AST_ACK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        start |=> !ack_q); // R8
    AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_q) |-> !ack_q); // R8
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc_q) |-> ($stable(mdo_q) && $stable(oe_q))); // R5
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_q && (pos != '0)) |-> oe_q); // R6
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_q && (pos > POS_TA)) |-> !oe_q); // R7

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output cmd_word_t         start_cmd,
    output logic [DIV_W-1:0]  div_val
);

    ctrl_word_t        ctrl_in;
    cmd_word_t         cmd_in;
    ctrl_word_t        ctrl_view;
    cmd_word_t         cmd_view;
    logic              wr_ctrl;
    logic              wr_cmd;
    logic [DIV_W-1:0]  div_q;
    logic              en_q;
    logic              fault_q;
    logic              fault_en_q;
    logic              cwr_q;
    logic [REGN_W-1:0] creg_q;
    logic [PHY_W-1:0]  cphy_q;
    logic [DATA_W-1:0] cdata_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q;
    logic [WORD_W-1:0] rd_view;
    logic              unused_in;

    assign ctrl_in   = ctrl_word_t'(req_wdata);
    assign cmd_in    = cmd_word_t'(req_wdata);
    assign unused_in = ^{ctrl_in.idle, ctrl_in.rsv_hi, ctrl_in.rsv_lo, cmd_in.ack, cmd_in.rsv};

    assign wr_ctrl = req_valid && req_write && (req_addr == ADDR_W'(ADDR_CTRL));
    assign wr_cmd  = req_valid && req_write && (req_addr == ADDR_W'(ADDR_CMD));

    assign start     = wr_cmd && cmd_in.go && en_q && !busy;
    assign start_cmd = cmd_in;
    assign div_val   = div_q;
    assign req_ready = 1'b1;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    always_comb begin
        ctrl_view          = '0;
        ctrl_view.idle     = en_q && !busy;
        ctrl_view.en       = en_q;
        ctrl_view.fault    = fault_q;
        ctrl_view.fault_en = fault_en_q;
        ctrl_view.div      = div_q;

        cmd_view      = '0;
        cmd_view.go   = busy;
        cmd_view.wr   = cwr_q;
        cmd_view.ack  = ack;
        cmd_view.regn = creg_q;
        cmd_view.phy  = cphy_q;
        cmd_view.data = cdata_q;

        if (req_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_view = ctrl_view;
        end else if (req_addr == ADDR_W'(ADDR_CMD)) begin
            rd_view = cmd_view;
        end else begin
            rd_view = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q       <= '0;
            en_q        <= 1'b0;
            fault_q     <= 1'b0;
            fault_en_q  <= 1'b0;
            cwr_q       <= 1'b0;
            creg_q      <= '0;
            cphy_q      <= '0;
            cdata_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            if (wr_ctrl) begin
                div_q      <= ctrl_in.div;
                en_q       <= ctrl_in.en;
                fault_q    <= ctrl_in.fault;
                fault_en_q <= ctrl_in.fault_en;
            end
            if (wr_cmd && !busy) begin
                cwr_q   <= cmd_in.wr;
                creg_q  <= cmd_in.regn;
                cphy_q  <= cmd_in.phy;
                cdata_q <= cmd_in.data;
            end else if (done && !cwr_q) begin
                cdata_q <= rd_data;
            end
            rsp_valid_q <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata_q <= rd_view;
            end
        end
    end

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({cwr_q, creg_q, cphy_q, cdata_q})); // R9

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    logic              start;
    cmd_word_t         start_cmd;
    logic [DIV_W-1:0]  div_val;
    logic              busy;
    logic              done;
    logic              ack;
    logic [DATA_W-1:0] rd_data;
    logic              fall_tick;
    logic              rise_tick;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .busy      (busy),
        .done      (done),
        .ack       (ack),
        .rd_data   (rd_data),
        .start     (start),
        .start_cmd (start_cmd),
        .div_val   (div_val)
    );

    mdio_mdc_gen u_mdc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .run       (busy),
        .div_in    (div_val),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );

    mdio_frame_eng u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (start_cmd),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .ack       (ack),
        .rdata     (rd_data),
        .mdc       (mdc),
        .mdo       (mdio_o),
        .mdo_oe    (mdio_oe)
    );

    AST_GO_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid && req_write)); // R3

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_addr = 2'd0;
    logic [31:0] req_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // waveform model state
    bit          m_arm = 0;
    bit          m_active = 0;
    int          m_t = 0;
    int          m_p = 2;
    bit          m_wr = 0;
    bit          m_ack_en = 0;
    logic [63:0] m_frame = '0;
    logic [15:0] m_phy_data = '0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cmd_word(bit go, bit wr, bit ack, logic [4:0] rg, logic [4:0] phy, logic [15:0] d);
        return {go, wr, ack, 3'b000, rg, phy, d};
    endfunction

    function automatic logic [63:0] exp_frame(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        logic [63:0] f;
        f[63:32] = 32'hFFFF_FFFF;
        f[31:30] = 2'b01;
        f[29:28] = wr ? 2'b01 : 2'b10;
        f[27:23] = phy;
        f[22:18] = rg;
        f[17:16] = wr ? 2'b10 : 2'b00;
        f[15:0]  = wr ? d : 16'h0000;
        return f;
    endfunction

    // cycle-by-cycle reference for MDC/MDIO and the PHY side
    always @(negedge clk) begin : model
        int u;
        int k;
        int c;
        bit em;
        bit eo;
        bit ed;
        if (rst) begin
            mdio_i = 1'b1;
        end else begin
            if (m_arm) begin
                m_active = 1;
                m_t = 0;
                m_arm = 0;
            end else if (m_active) begin
                m_t++;
            end
            k = -1;
            em = 0; eo = 0; ed = 0;
            if (m_active && m_t >= 1) begin
                u = m_t - 1;
                k = u / m_p;
                c = u % m_p;
                if (k >= 64) begin
                    m_active = 0;
                    k = -1;
                end else begin
                    em = (c >= m_p / 2);
                    eo = m_wr || (k < 46);
                    ed = m_frame[63-k];
                end
            end
            if (k < 0) begin
                chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle lines", {30'd0, mdc, mdio_oe}, 32'd0);
            end else begin
                chk(mdc === em, "R4 mdc", {31'd0, mdc}, {31'd0, em});
                if (m_wr) chk(mdio_oe === eo, "R6 oe", {31'd0, mdio_oe}, {31'd0, eo});
                else      chk(mdio_oe === eo, "R7 oe", {31'd0, mdio_oe}, {31'd0, eo});
                if (eo) chk(mdio_o === ed, "R5 bit", k, {31'd0, ed});
            end
            mdio_i = 1'b1;
            if (k >= 0 && !m_wr && m_ack_en) begin
                if (k == 47) mdio_i = 1'b0;
                else if (k >= 48) mdio_i = m_phy_data[63-k];
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input bit arm);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk);
        if (arm) m_arm = 1;
        #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk);
        #1;
        req_valid = 0;
        @(negedge clk);
        chk(rsp_valid === 1'b1 && req_ready === 1'b1, "R11 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 single pulse", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic run_cmd(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d,
                           input int p, input bit acken, input logic [15:0] pd);
        m_wr = wr; m_p = p; m_ack_en = acken; m_phy_data = pd;
        m_frame = exp_frame(wr, phy, rg, d);
        bus_write(2'd1, cmd_word(1'b1, wr, 1'b0, rg, phy, d), 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_active || m_arm) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin : stim
        logic [31:0] r;
        logic [31:0] e;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, r); chk(r === 32'd0, "R1 ctrl reset", r, 32'd0);
        bus_read(2'd1, r); chk(r === 32'd0, "R1 cmd reset", r, 32'd0);

        // R10 disabled: GO does nothing
        bus_write(2'd0, 32'h0000_0003, 0);
        bus_write(2'd1, cmd_word(1'b1, 1'b0, 1'b0, 5'h01, 5'h02, 16'h0000), 0);
        bus_read(2'd1, r); chk(r[31] === 1'b0, "R10 go stays 0", r, 32'd0);
        repeat (20) @(negedge clk);
        bus_read(2'd0, r); chk(r === 32'h0000_0003, "R2 disabled idle 0", r, 32'h0000_0003);

        // R2 control fields
        bus_write(2'd0, 32'h400C_0003, 0);
        bus_read(2'd0, r); chk(r === 32'hC00C_0003, "R2 ctrl readback", r, 32'hC00C_0003);

        // R6 write frame, divider 3
        run_cmd(1'b1, 5'h05, 5'h1A, 16'hBEEF, 4, 1'b0, 16'h0);
        bus_read(2'd1, r); chk(r[31] === 1'b1, "R3 go while running", r, 32'h8000_0000);
        bus_read(2'd0, r); chk(r === 32'h400C_0003, "R2 idle low while busy", r, 32'h400C_0003);
        wait_idle();
        e = cmd_word(1'b0, 1'b1, 1'b0, 5'h1A, 5'h05, 16'hBEEF);
        bus_read(2'd1, r); chk(r === e, "R6 write result", r, e);

        // R7 read with acknowledge, divider 1
        bus_write(2'd0, 32'h4000_0001, 0);
        run_cmd(1'b0, 5'h11, 5'h02, 16'h0000, 2, 1'b1, 16'h1234);
        wait_idle();
        exp_q.push_back(cmd_word(1'b0, 1'b0, 1'b1, 5'h02, 5'h11, 16'h1234));
        bus_read(2'd1, r); e = exp_q.pop_front(); chk(r === e, "R7 read data and ack", r, e);

        // R8 write after acknowledged read: ack cleared
        run_cmd(1'b1, 5'h07, 5'h09, 16'h0F0F, 2, 1'b0, 16'h0);
        wait_idle();
        e = cmd_word(1'b0, 1'b1, 1'b0, 5'h09, 5'h07, 16'h0F0F);
        bus_read(2'd1, r); chk(r === e, "R8 ack 0 after write", r, e);

        // R8 read without acknowledge, divider 4
        bus_write(2'd0, 32'h4000_0004, 0);
        run_cmd(1'b0, 5'h03, 5'h1F, 16'hAAAA, 5, 1'b0, 16'h0);
        wait_idle();
        e = cmd_word(1'b0, 1'b0, 1'b0, 5'h1F, 5'h03, 16'hFFFF);
        bus_read(2'd1, r); chk(r === e, "R8 no ack read", r, e);

        // R9 command during a running frame is ignored
        bus_write(2'd0, 32'h4000_0002, 0);
        run_cmd(1'b1, 5'h0A, 5'h04, 16'h5A5A, 3, 1'b0, 16'h0);
        repeat (30) @(negedge clk);
        bus_write(2'd1, cmd_word(1'b1, 1'b0, 1'b0, 5'h1F, 5'h1F, 16'h0000), 0);
        wait_idle();
        e = cmd_word(1'b0, 1'b1, 1'b0, 5'h04, 5'h0A, 16'h5A5A);
        bus_read(2'd1, r); chk(r === e, "R9 fields kept", r, e);
        repeat (10) @(negedge clk);

        // R4 divider 0 behaves as 1
        bus_write(2'd0, 32'h4000_0000, 0);
        run_cmd(1'b0, 5'h1F, 5'h00, 16'h0000, 2, 1'b1, 16'h8001);
        wait_idle();
        e = cmd_word(1'b0, 1'b0, 1'b1, 5'h00, 5'h1F, 16'h8001);
        bus_read(2'd1, r); chk(r === e, "R4 divider zero read", r, e);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule